// File: doc/BRIEF.md
# Prescaled Watchdog Timer Channel

This block is one timer channel that supervises a single real-time task. A 1 MHz reference strobe (one system-clock cycle wide, in the system clock domain) feeds a free-running divider. A two-bit rate field picks a step rate of 1, 1/4, 1/16 or 1/64 of that reference. A 16-bit down-counter is loaded from the host data word and moves one count per step while the channel is enabled. When it reaches zero it raises a one-cycle terminal-count pulse, which the interrupt logic outside this block uses as the channel's request.

Software uses the channel in two ways. As a watchdog it loads a deadline and reloads ("kicks") it before expiry. As an event timestamp source it reads the live count onto the data bus while the output enable is held. Bus decoding and interrupt prioritisation sit outside the block.

Top module: `wdt_channel`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the channel is stopped, `tc` is low, the rate field is 0 (divide by 1) and the enable bit is 0.
- R2: A cycle with `cmd_wr` high stores `host_wdata[1:0]` as the rate field and `host_wdata[2]` as the enable bit. `host_wdata[15:3]` has no effect on the channel. Without `cmd_wr` both fields hold.
- R3: Counting `ref_tick` pulses from reset as k = 1, 2, 3 and so on, pulse k is a count step when k mod N = 0. N is 1, 4, 16 or 64 for rate field values 0, 1, 2 and 3. The divider keeps running whatever the enable, load or rate settings are.
- R4: `load` copies `host_wdata` into the count and clears any `tc` in the following cycle. The channel runs after the load only if the value is nonzero. A load in the same cycle as a step wins, and that step is lost.
- R5: On a step, while enabled and running and with no load, the count drops by exactly one. The new value can be read in the next cycle.
- R6: While the enable bit is 0 the count does not change, except by a load.
- R7: A step that takes the count from 1 to 0 makes `tc` high for exactly one clock cycle, in the cycle after that step. The count then stays at 0 and the channel stays stopped until the next load.
- R8: `rd_data` equals the current count while `oe` is high and is 0 while `oe` is low. It follows `oe` in the same cycle.
- R9: Loading 0 leaves the channel stopped. No `tc` is raised, whatever steps follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | 1 MHz reference strobe, one clock cycle wide |
| host_wdata | input | 16 | Host write data for loads and command writes |
| cmd_wr | input | 1 | Writes the command fields from host_wdata[2:0] |
| load | input | 1 | Loads the count from host_wdata |
| oe | input | 1 | Puts the count on rd_data |
| rd_data | output | 16 | Count readback, 0 when oe is low |
| tc | output | 1 | One-cycle terminal-count pulse |

## Verification
The collision that matters is a reload arriving in the same cycle as a count step. This is worst on the step that would take the count from 1 to 0, where a host kick races the expiry. The bench provokes it in two ways. First, a directed kick lands exactly on the expiring step at divide-by-1. Second, a long random phase drives reference strobes, small reloads and command writes densely enough that they often coincide. Each outcome is judged against a behavioural model that applies load-over-step priority. The model checks that no `tc` appears and that the count equals the reloaded value. Command writes that share a cycle with a step are also compared, and the step must use the old rate and enable.

// File: rtl/wdt_pkg.sv
// Shared types and constants for the prescaled watchdog channel.
// Assumes the command fields sit in the low bits of the host data word.
package wdt_pkg;

    localparam int NUM_RATES = 4;                          // selectable step rates
    localparam int STEP_LOG  = 2;                          // log2 of ratio between rates
    localparam int SEL_W     = $clog2(NUM_RATES);
    localparam int DIV_W     = STEP_LOG * (NUM_RATES - 1); // free-running divider width

    typedef enum logic [SEL_W-1:0] {
        RATE_DIV1  = 2'd0,
        RATE_DIV4  = 2'd1,
        RATE_DIV16 = 2'd2,
        RATE_DIV64 = 2'd3
    } rate_sel_e;

    // Packed: run_en lands on bit 2, rate on bits [1:0].
    typedef struct packed {
        logic      run_en;
        rate_sel_e rate;
    } chan_cmd_t;

    localparam int CMD_W = $bits(chan_cmd_t);

endpackage

// File: rtl/wdt_cmd_reg.sv
// Command register for one channel: stores the rate field and the run enable.
// Assumes the caller passes only the command bits of the host word.
module wdt_cmd_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CMD_W-1:0] wbits,
    output chan_cmd_t        cmd
);

    // Capture the command fields on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '{run_en: 1'b0, rate: RATE_DIV1};
        end else if (wr) begin
            cmd <= chan_cmd_t'(wbits);
        end
    end

    // R2: fields hold while no write is issued
    a_r2_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cmd));

    // R2: a write lands exactly the presented bits
    a_r2_cmd_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cmd == $past(wbits)));

endmodule

// File: rtl/wdt_prescaler.sv
// Rate divider: a free-running counter of reference strobes, tapped to make
// a single-cycle step enable at 1, 1/4, 1/16 or 1/64 of the reference rate.
// Assumes ref_tick is a one-cycle strobe in the clk domain; no clock is gated.
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);

    logic [DIV_W-1:0]     div_q;
    logic [NUM_RATES-1:0] tap;

    // Count reference strobes, wrapping at the full divider width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (ref_tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    // One tap per rate: true when the low bits of the divider are all ones.
    for (genvar r = 0; r < NUM_RATES; r++) begin : g_tap
        localparam logic [DIV_W-1:0] MASK = {DIV_W{1'b1}} >> (DIV_W - r * STEP_LOG);
        assign tap[r] = ((div_q & MASK) == MASK);
    end

    // Gate the selected tap with the strobe to form the step enable.
    always_comb begin
        step = ref_tick & tap[sel];
    end

    // R3: a step only happens on a reference strobe
    a_r3_step_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ref_tick);

    // R3: at a divided rate two steps are never back to back
    a_r3_no_double_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sel != '0) |=> !(step && sel == $past(sel)));

endmodule

// File: rtl/wdt_down_counter.sv
// Loadable down-counter with terminal-count pulse. It counts one per step
// while enabled and running, stops at zero, and pulses tc once on expiry.
// A load has priority over a same-cycle step and clears any pending tc.
module wdt_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             tc
);

    localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b0}}, 1'b1};

    logic running;

    // Load, count down, and flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            tc      <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (load) begin
                cnt     <= load_val;
                running <= |load_val;
            end else if (en && running && step) begin
                cnt <= cnt - 1'b1;
                if (cnt == LAST) begin
                    running <= 1'b0;
                    tc      <= 1'b1;
                end
            end
        end
    end

    // R4: load takes effect and removes any tc
    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)) && !tc);

    // R5: a qualified step removes exactly one count
    a_r5_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && running && step) |=> (cnt == $past(cnt) - 1'b1));

    // R6: disabled channel holds its count
    a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(cnt));

    // R7: tc is a single pulse, seen only at count zero when stopped
    a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (cnt == '0) && !running);

    // R7, R9: a stopped channel does not move without a load
    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !running) |=> $stable(cnt) && !tc);

endmodule

// File: rtl/wdt_channel.sv
// One prescaled watchdog / timestamp channel: command register, rate divider,
// down-counter and readback gate. Assumes host_wdata is as wide as the count
// and that bus decoding and interrupt arbitration are done by the caller.
module wdt_channel
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cmd_wr,
    input  logic              load,
    input  logic              oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              tc
);

    chan_cmd_t        cmd;
    logic             step;
    logic [CNT_W-1:0] cnt;

    wdt_cmd_reg i_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cmd_wr),
        .wbits (host_wdata[CMD_W-1:0]),
        .cmd   (cmd)
    );

    wdt_prescaler i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .sel      (cmd.rate),
        .step     (step)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (host_wdata[CNT_W-1:0]),
        .en       (cmd.run_en),
        .step     (step),
        .cnt      (cnt),
        .tc       (tc)
    );

    // Drive the count onto the read bus only while the output enable is set.
    always_comb begin
        rd_data = '0;
        if (oe) begin
            rd_data = DATA_W'(cnt);
        end
    end

    // R7, R8: an expiry reads back as zero
    a_r8_tc_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && oe) |-> (rd_data == '0));

    // R8: the bus is quiet while not enabled
    a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (rd_data == '0));

endmodule

// File: tb/test_wdt_channel.sv
// Bench for wdt_channel: a behavioural model is stepped once per clock and
// its count and tc are compared with the design at every negative edge.
module test_wdt_channel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick;
    logic [15:0] host_wdata;
    logic        cmd_wr;
    logic        load;
    logic        oe;
    logic [15:0] rd_data;
    logic        tc;

    always #5 clk = ~clk;

    wdt_channel i_wdt_channel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .host_wdata (host_wdata),
        .cmd_wr     (cmd_wr),
        .load       (load),
        .oe         (oe),
        .rd_data    (rd_data),
        .tc         (tc)
    );

    int    vecs = 0;
    int    errs = 0;
    string phase = "R1";

    // behavioural model state
    int m_div, m_sel, m_en, m_cnt, m_run, m_tc;

    task automatic check(string what, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step(bit r, bit cw, bit ld, int d);
        bit step = 1'b0;
        if (r) begin
            int k = m_div + 1;
            int n = 1 << (2 * m_sel);
            step  = ((k % n) == 0);
            m_div = k % 64;
        end
        m_tc = 0;
        if (ld) begin
            m_cnt = d;
            m_run = (d != 0);
        end else if (m_en != 0 && m_run != 0 && step) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_run = 0;
                m_tc  = 1;
            end
        end
        if (cw) begin
            m_sel = d & 3;
            m_en  = (d >> 2) & 1;
        end
    endtask

    // Apply one cycle of stimulus, compare outputs, then advance the model.
    task automatic cycle(bit r, bit cw, bit ld, bit o, int d);
        @(negedge clk);
        ref_tick   = r;
        cmd_wr     = cw;
        load       = ld;
        oe         = o;
        host_wdata = d[15:0];
        #1;
        check("tc (R7)", int'(tc), m_tc);
        if (o) check("count (R5)", int'(rd_data), m_cnt);
        else   check("bus idle (R8)", int'(rd_data), 0);
        model_step(r, cw, ld, d);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ref_tick = 0; cmd_wr = 0; load = 0; oe = 0; host_wdata = '0;
        m_div = 0; m_sel = 0; m_en = 0; m_cnt = 0; m_run = 0; m_tc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        oe = 1'b1;
        #1;
        // R1: reset state visible at the ports
        check("reset count (R1)", int'(rd_data), 0);
        check("reset tc (R1)", int'(tc), 0);
        rst_n = 1'b1;
        cycle(1, 0, 0, 1, 0);
        cycle(1, 0, 0, 1, 0);

        // R2: upper bits ignored, enable still 0, count held
        phase = "R2";
        cycle(0, 1, 0, 1, 16'hFFF8);
        cycle(0, 0, 1, 1, 5);
        for (int i = 0; i < 6; i++) cycle(1, 0, 0, 1, 0);
        cycle(0, 1, 0, 1, 16'hABC4);
        for (int i = 0; i < 3; i++) cycle(1, 0, 0, 1, 0);

        // R3: each divided rate, with gaps between strobes
        phase = "R3";
        for (int s = 1; s < 4; s++) begin
            cycle(0, 1, 0, 1, 4 | s);
            cycle(0, 0, 1, 1, 300);
            for (int i = 0; i < 200; i++) cycle(1, 0, 0, i % 3 != 0, 0);
            for (int i = 0; i < 60; i++) cycle(i % 2 == 0, 0, 0, 1, 0);
        end

        // R6: disabled hold with strobes, then resume
        phase = "R6";
        cycle(0, 1, 0, 1, 0);
        for (int i = 0; i < 20; i++) cycle(1, 0, 0, 1, 0);
        cycle(0, 1, 0, 1, 4);
        for (int i = 0; i < 4; i++) cycle(1, 0, 0, 1, 0);

        // R7: expiry pulse and stop at zero
        phase = "R7";
        cycle(0, 0, 1, 1, 3);
        for (int i = 0; i < 8; i++) cycle(1, 0, 0, 1, 0);

        // R4: kick on the expiring step, and reload during tc
        phase = "R4";
        cycle(0, 0, 1, 1, 2);
        cycle(1, 0, 0, 1, 0);
        cycle(1, 0, 1, 1, 7);
        for (int i = 0; i < 7; i++) cycle(1, 0, 0, 1, 0);
        cycle(1, 0, 1, 1, 4);
        for (int i = 0; i < 3; i++) cycle(1, 0, 0, 1, 0);
        cycle(1, 1, 0, 1, 5);
        cycle(1, 0, 0, 1, 0);

        // R9: zero load stays stopped, no tc
        phase = "R9";
        cycle(0, 1, 0, 1, 4);
        cycle(0, 0, 1, 1, 0);
        for (int i = 0; i < 10; i++) cycle(1, 0, 0, 1, 0);

        // R5, R8: dense random traffic with collisions
        phase = "R5";
        for (int i = 0; i < 4000; i++) begin
            bit r  = ($urandom % 2) == 0;
            bit cw = ($urandom % 16) == 0;
            bit ld = ($urandom % 24) == 0;
            bit o  = ($urandom % 4) != 0;
            int d  = cw ? int'($urandom % 65536) : int'($urandom % 40);
            if (cw && ($urandom % 2) == 0) d = d | 4;
            cycle(r, cw, ld, o, d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule